// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Nibble-Carry and Byte-Parity Flags

This block adds or subtracts two parameter-width integers and reports the result on the same cycle, with no register in the path. It also builds the four usual condition flags: negative, zero, carry and signed overflow. When a compatibility input is high, it builds two more flags in that same pass: a nibble carry (a carry or borrow across the bit 3 / bit 4 boundary) and an even-parity indication on the low byte of the result. Software that emulates an older instruction set can then get those flags from one operation instead of a sequence of extra instructions.

The flags are held in a six-bit flag register. It loads only on a clock edge where a flag-set request is high. With the compatibility input low, the unit behaves as a plain native adder. Its live legacy outputs read zero, the register keeps the legacy bits it held before, and a subtract reports carry as "no borrow". With the input high, a subtract reports carry as "borrow".

Top module: `lf_addsub`

## Requirements
- R1: `result` equals `op_a + op_b` modulo 2^W when `sub` is 0, and `op_a - op_b` modulo 2^W when `sub` is 1, on the same cycle as the operands.
- R2: On a flag load, `flg_n` takes bit W-1 of `result`, and `flg_z` is 1 exactly when `result` is all zeros.
- R3: On an add with a flag load, `flg_c` takes the carry out of bit W-1.
- R4: On a subtract with a flag load, `flg_c` is 1 when `op_a >= op_b` (unsigned) with `compat` = 0, and 1 when `op_a < op_b` with `compat` = 1.
- R5: On a flag load, `flg_o` is 1 when the two operands share a sign bit and the result sign differs from it. For this test the second operand is first inverted when `sub` = 1.
- R6: With `compat` = 1, the nibble-carry flag is 1 on an add when `op_a[3:0] + op_b[3:0]` exceeds 15, and on a subtract when `op_a[3:0] < op_b[3:0]`. Both `aux_now` and `flg_aux` (on a load) show it.
- R7: With `compat` = 1, the parity flag is 1 when `result[7:0]` holds an even number of ones. Both `par_now` and `flg_par` (on a load) show it.
- R8: With `compat` = 0, `aux_now` and `par_now` are 0 whatever the operands.
- R9: With `set_flags` = 0 at a clock edge, none of the six registered flags changes.
- R10: A flag load with `compat` = 0 updates `flg_n`, `flg_z`, `flg_c` and `flg_o`, while `flg_aux` and `flg_par` keep their earlier values.
- R11: A clock edge with `rst` = 1 clears all six registered flags, even when `set_flags` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub | input | 1 | 0 = add, 1 = subtract |
| set_flags | input | 1 | Load the flag register at this edge |
| compat | input | 1 | Enables the legacy flags and borrow-style carry |
| result | output | W | Sum or difference (combinational) |
| aux_now | output | 1 | Live nibble-carry flag, 0 unless compat |
| par_now | output | 1 | Live low-byte even-parity flag, 0 unless compat |
| flg_n | output | 1 | Registered negative flag |
| flg_z | output | 1 | Registered zero flag |
| flg_c | output | 1 | Registered carry flag |
| flg_o | output | 1 | Registered signed-overflow flag |
| flg_aux | output | 1 | Registered nibble-carry flag |
| flg_par | output | 1 | Registered parity flag |

## Verification
The bench builds the unit at W = 32, the default. At that width the wrap points 0xFFFFFFFF + 1 and 0x80000000 - 1, and the signed boundary 0x7FFFFFFF, can all be written directly as stimulus. This lets the zero, carry and overflow corners be hit on purpose. The nibble and byte boundaries do not depend on W, so a single build covers the legacy flags in both modes. It also covers the hold behaviour when loading flags with the mode bit low.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // Bit position where the nibble carry is observed
    localparam int NIB_BIT  = 4;
    // Number of low result bits the parity covers
    localparam int PAR_BITS = 8;
    // Number of flags in the register
    localparam int NFLAGS   = 6;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } lf_op_e;

    // Packed order: neg is the top bit, par is bit 0
    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
        logic aux;
        logic par;
    } lf_flags_t;

    // Bits of the flag vector that belong to the legacy pair
    localparam logic [NFLAGS-1:0] LEGACY_MASK = 6'b000011;

    function automatic logic even_ones(input logic [PAR_BITS-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/lf_adder.sv
module lf_adder
    import lf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lf_op_e       op,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf,
    output logic         nib
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] mix;

    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        cin   = (op == OP_SUB);
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        // Carry into bit 4 shows up as the xor of the three vectors there
        mix = a ^ b ^ sum;
        nib = mix[NIB_BIT];
    end

endmodule

// File: rtl/lf_flaggen.sv
module lf_flaggen
    import lf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         ovf,
    input  logic         nib,
    input  lf_op_e       op,
    input  logic         compat,
    output lf_flags_t    flags
);
    always_comb begin
        flags.neg   = sum[W-1];
        flags.zero  = (sum == '0);
        // Subtract: native carry means "no borrow", compat carry means "borrow"
        if (op == OP_SUB && compat) flags.carry = ~cout;
        else                        flags.carry = cout;
        flags.ovf   = ovf;
        flags.aux   = compat ? nib : 1'b0;
        flags.par   = compat ? even_ones(sum[PAR_BITS-1:0]) : 1'b0;
    end

endmodule

// File: rtl/lf_flagreg.sv
module lf_flagreg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    input  logic [N-1:0] en,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= 1'b0;
            else if (en[i]) q[i] <= d[i];
        end
    end

endmodule

// File: rtl/lf_addsub.sv
module lf_addsub
    import lf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub,
    input  logic         set_flags,
    input  logic         compat,
    output logic [W-1:0] result,
    output logic         aux_now,
    output logic         par_now,
    output logic         flg_n,
    output logic         flg_z,
    output logic         flg_c,
    output logic         flg_o,
    output logic         flg_aux,
    output logic         flg_par
);
    lf_op_e          op;
    logic            cout, ovf, nib;
    lf_flags_t       live;
    lf_flags_t       held;
    logic [NFLAGS-1:0] load_en;

    assign op = sub ? OP_SUB : OP_ADD;

    lf_adder #(.W(W)) u_add (
        .a    (op_a),
        .b    (op_b),
        .op   (op),
        .sum  (result),
        .cout (cout),
        .ovf  (ovf),
        .nib  (nib)
    );

    lf_flaggen #(.W(W)) u_gen (
        .sum    (result),
        .cout   (cout),
        .ovf    (ovf),
        .nib    (nib),
        .op     (op),
        .compat (compat),
        .flags  (live)
    );

    // Legacy bits load only when the compatibility mode is on
    always_comb begin
        for (int i = 0; i < NFLAGS; i++)
            load_en[i] = set_flags & (LEGACY_MASK[i] ? compat : 1'b1);
    end

    lf_flagreg #(.N(NFLAGS)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (live),
        .en  (load_en),
        .q   (held)
    );

    assign aux_now = live.aux;
    assign par_now = live.par;
    assign flg_n   = held.neg;
    assign flg_z   = held.zero;
    assign flg_c   = held.carry;
    assign flg_o   = held.ovf;
    assign flg_aux = held.aux;
    assign flg_par = held.par;

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flg_z == ($past(result) == '0)));

    // R9
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable({flg_n, flg_z, flg_c, flg_o, flg_aux, flg_par}));

    // R10
    legacy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_flags && !compat) |=> $stable({flg_aux, flg_par}));

    // R8
    live_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !compat |-> (!aux_now && !par_now));

    // R7
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (set_flags && compat) |=> (flg_par == ~(^$past(result[7:0]))));

    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flg_n == $past(result[W-1])));

endmodule

// File: tb/lf_addsub_test.sv
module lf_addsub_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         sub = 1'b0, set_flags = 1'b0, compat = 1'b0;
    logic [W-1:0] result;
    logic aux_now, par_now, flg_n, flg_z, flg_c, flg_o, flg_aux, flg_par;

    always #4 clk = ~clk;

    lf_addsub #(.W(W)) uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub(sub),
        .set_flags(set_flags), .compat(compat), .result(result),
        .aux_now(aux_now), .par_now(par_now), .flg_n(flg_n), .flg_z(flg_z),
        .flg_c(flg_c), .flg_o(flg_o), .flg_aux(flg_aux), .flg_par(flg_par)
    );

    typedef struct {
        logic [5:0] f;      // n z c o aux par
        logic       s, cm, st, r;
    } item_t;

    item_t q[$];
    logic [5:0] mdl = '0;
    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input logic st, input logic cm);
        logic [W:0] ext;
        logic [W-1:0] res;
        logic c, o, nb, pr;
        item_t it;
        @(negedge clk);
        rst = r; op_a = a; op_b = b; sub = s; set_flags = st; compat = cm;
        #1;
        if (!s) ext = {1'b0, a} + {1'b0, b};
        else    ext = {1'b0, a} - {1'b0, b};
        res = ext[W-1:0];
        if (!s) begin
            c  = ext[W];
            nb = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            o  = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
        end else begin
            c  = cm ? ext[W] : ~ext[W];
            nb = a[3:0] < b[3:0];
            o  = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
        end
        pr = ($countones(res[7:0]) % 2) == 0;
        chk("R1", "result", 64'(result), 64'(res));
        if (cm) begin
            chk("R6", "aux_now", 64'(aux_now), 64'(nb));
            chk("R7", "par_now", 64'(par_now), 64'(pr));
        end else begin
            chk("R8", "aux_now", 64'(aux_now), 64'd0);
            chk("R8", "par_now", 64'(par_now), 64'd0);
        end
        if (r) mdl = '0;
        else if (st) begin
            mdl[5] = res[W-1];
            mdl[4] = (res == '0);
            mdl[3] = c;
            mdl[2] = o;
            if (cm) begin mdl[1] = nb; mdl[0] = pr; end
        end
        it.f = mdl; it.s = s; it.cm = cm; it.st = st; it.r = r;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        string ctx;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                ctx = it.r ? "R11" : (!it.st ? "R9" : "");
                if (ctx != "") begin
                    chk(ctx, "flags", 64'({flg_n, flg_z, flg_c, flg_o, flg_aux, flg_par}), 64'(it.f));
                end else begin
                    chk("R2", "flg_n", 64'(flg_n), 64'(it.f[5]));
                    chk("R2", "flg_z", 64'(flg_z), 64'(it.f[4]));
                    chk(it.s ? "R4" : "R3", "flg_c", 64'(flg_c), 64'(it.f[3]));
                    chk("R5", "flg_o", 64'(flg_o), 64'(it.f[2]));
                    chk(it.cm ? "R6" : "R10", "flg_aux", 64'(flg_aux), 64'(it.f[1]));
                    chk(it.cm ? "R7" : "R10", "flg_par", 64'(flg_par), 64'(it.f[0]));
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        logic [W-1:0] lf;
        lf = 32'h1234_5678;
        // R11: reset with load requested
        for (int i = 0; i < 3; i++) step(1, 32'hFFFF_FFFF, 32'h1, 0, 1, 1);
        // native mode corners
        step(0, 32'd5, 32'd3, 0, 1, 0);
        step(0, 32'hFFFF_FFFF, 32'd1, 0, 1, 0);     // zero, carry (R3)
        step(0, 32'h7FFF_FFFF, 32'd1, 0, 1, 0);     // overflow, negative (R5)
        step(0, 32'd5, 32'd3, 1, 1, 0);             // R4 native, no borrow -> 1
        step(0, 32'd3, 32'd5, 1, 1, 0);             // R4 native, borrow -> 0
        step(0, 32'h8000_0000, 32'd1, 1, 1, 0);     // R5 subtract overflow
        step(0, 32'd0, 32'd0, 0, 0, 1);             // R9 no load
        step(0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        // compatibility mode
        step(0, 32'h0F, 32'h01, 0, 1, 1);           // R6 nibble carry, R7 parity odd
        step(0, 32'h10, 32'h01, 1, 1, 1);           // R6 nibble borrow, R7 even
        step(0, 32'd3, 32'd5, 1, 1, 1);             // R4 compat borrow -> 1
        step(0, 32'd1, 32'd2, 0, 1, 1);
        // R10: native load keeps legacy bits
        step(0, 32'h0F, 32'h0F, 0, 1, 1);
        step(0, 32'h01, 32'h00, 0, 1, 0);
        step(0, 32'h11, 32'h22, 1, 0, 1);           // R9 hold while compat
        // mid-run reset
        step(1, 32'h8, 32'h8, 0, 1, 1);
        step(0, 32'h8, 32'h8, 0, 1, 1);
        // pseudo-random sweep over both modes
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] x, y;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            x = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            y = (i % 7 == 0) ? x : {lf[15:0], lf[31:16]};
            step(0, x, y, lf[3], lf[5] | lf[9], lf[7]);
        end
        step(0, '0, '0, 0, 0, 0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule